// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level table structure that lives in ordinary memory. A request carries the linear address, a write flag and a user-mode flag. The block then reads a directory entry, which points to a page table, and reads a table entry, which points to a 4 KB page frame. Both entries are checked for presence and for access rights. The walk finishes with either a physical address or a fault that names its cause and the level at which it occurred.

All memory traffic goes through one request/response port, with at most one access in flight at a time. On a granted access the block writes the entries back so that the accessed flag is set at both levels and, on a write, the dirty flag is set in the table entry. An entry is written back only when one of its flags actually changes. A denied or non-present walk leaves memory untouched. The directory's frame number comes from a base input, which is sampled when a request is accepted.

Top module: `pgwalk`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0 and `mem_req` is 0. A request is accepted only while `ready` is 1.
- R2: The first memory access of every walk is a read at {`root_frame`, va[31:22], 2'b00}.
- R3: The second access is a read at {directory entry[31:12], va[21:12], 2'b00}. On success, `phys_addr` = {table entry[31:12], va[11:0]}.
- R4: Bit 0 of an entry is the present flag. If the directory entry has bit 0 clear, the walk ends with `fault`=1, `fault_prot`=0, `fault_level`=0 and no second read. If the table entry has bit 0 clear, it ends with `fault`=1, `fault_prot`=0, `fault_level`=1.
- R5: When both entries are present, a write needs bit 1 set in both entries, and a user access needs bit 2 set in both. Otherwise the walk ends with `fault`=1 and `fault_prot`=1. `fault_level` is 0 if the directory entry denies the access, and 1 if only the table entry denies it.
- R6: A walk that ends in any fault performs no memory write.
- R7: On success, the directory entry is rewritten with bit 5 (accessed) set, but only if that bit was clear. The table entry is rewritten with bit 5 set, and with bit 6 (dirty) set on a write, but only if one of those bits changes. The directory write comes before the table write. All other bits are written back unchanged.
- R8: Only one memory access is outstanding at a time. While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay stable.
- R9: `done` is a one-cycle pulse per accepted request. The result outputs are valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when ready) |
| req_va | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| root_frame | input | 20 | Frame number of the directory |
| ready | output | 1 | Idle, can accept a request |
| done | output | 1 | Walk result valid (one cycle) |
| fault | output | 1 | Walk ended in a fault |
| fault_prot | output | 1 | 1 = protection fault, 0 = not present |
| fault_level | output | 1 | 0 = directory level, 1 = table level |
| phys_addr | output | 32 | Translated physical address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Random walks draw entries with random present, write, user, accessed and dirty flags, so every fault class and every write-back combination comes up. The clean walks check the address composition at both levels. Walks with accessed and dirty flags already set show whether a write-back is skipped or always performed. Walks that are denied at only one level show whether both levels are consulted and whether the reported level is right. Directed cases put a non-present entry at each level and combine user and write denials. Throughout, the memory model acknowledges after random delays, which exposes any request that is not held stable.

// File: rtl/pgwalk.sv
module pgwalk #(
  parameter int PAGE_BITS = 12,
  parameter int IDX_BITS  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31-PAGE_BITS:0] root_frame,
  output logic        ready,
  output logic        done,
  output logic        fault,
  output logic        fault_prot,
  output logic        fault_level,
  output logic [31:0] phys_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int FRAME_W = 32 - PAGE_BITS;
  localparam int DIR_LO  = PAGE_BITS + IDX_BITS;
  localparam int B_P = 0, B_RW = 1, B_US = 2, B_A = 5, B_D = 6;

  typedef enum logic [2:0] {S_IDLE, S_RDIR, S_RTBL, S_WDIR, S_WTBL, S_DONE} state_t;
  state_t state;

  logic [31:0]        va_q, pde_q, pte_q;
  logic [FRAME_W-1:0] root_q;
  logic               wr_q, usr_q;

  logic dir_deny, tbl_deny, tbl_wb_new, tbl_wb_q;
  assign dir_deny   = (wr_q && !pde_q[B_RW]) || (usr_q && !pde_q[B_US]);
  assign tbl_deny   = (wr_q && !mem_rdata[B_RW]) || (usr_q && !mem_rdata[B_US]);
  assign tbl_wb_new = !mem_rdata[B_A] || (wr_q && !mem_rdata[B_D]);
  assign tbl_wb_q   = !pte_q[B_A] || (wr_q && !pte_q[B_D]);

  logic [31:0] dir_ea, tbl_ea;
  assign dir_ea = {root_q, va_q[31:DIR_LO], 2'b00};
  assign tbl_ea = {pde_q[31:PAGE_BITS], va_q[DIR_LO-1:PAGE_BITS], 2'b00};

  assign ready     = state == S_IDLE;
  assign done      = state == S_DONE;
  assign mem_req   = state inside {S_RDIR, S_RTBL, S_WDIR, S_WTBL};
  assign mem_we    = state inside {S_WDIR, S_WTBL};
  assign mem_addr  = (state == S_RDIR || state == S_WDIR) ? dir_ea : tbl_ea;
  assign mem_wdata = (state == S_WDIR) ? (pde_q | (32'd1 << B_A))
                   : (pte_q | (32'd1 << B_A) | ({31'd0, wr_q} << B_D));
  assign phys_addr = {pte_q[31:PAGE_BITS], va_q[PAGE_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      va_q <= '0; pde_q <= '0; pte_q <= '0; root_q <= '0;
      wr_q <= 1'b0; usr_q <= 1'b0;
      fault <= 1'b0; fault_prot <= 1'b0; fault_level <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q <= req_va; wr_q <= req_write; usr_q <= req_user; root_q <= root_frame;
          fault <= 1'b0; fault_prot <= 1'b0; fault_level <= 1'b0;
          state <= S_RDIR;
        end
        S_RDIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            fault <= 1'b1; fault_level <= 1'b0; state <= S_DONE;
          end else state <= S_RTBL;
        end
        S_RTBL: if (mem_ack) begin
          pte_q <= mem_rdata;
          if (!mem_rdata[B_P]) begin
            fault <= 1'b1; fault_level <= 1'b1; state <= S_DONE;
          end else if (dir_deny || tbl_deny) begin
            fault <= 1'b1; fault_prot <= 1'b1; fault_level <= !dir_deny; state <= S_DONE;
          end else if (!pde_q[B_A]) state <= S_WDIR;
          else if (tbl_wb_new)      state <= S_WTBL;
          else                      state <= S_DONE;
        end
        S_WDIR: if (mem_ack) state <= tbl_wb_q ? S_WTBL : S_DONE;
        S_WTBL: if (mem_ack) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_req && !done);
  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_write_needs_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> pde_q[B_P] && pte_q[B_P] && !fault);
  assert_wb_sets_accessed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[B_A]);
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> phys_addr[PAGE_BITS-1:0] == va_q[PAGE_BITS-1:0]);
  assert_np_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault && !fault_prot && !fault_level |-> !pde_q[B_P]);
endmodule

// File: tb/sim_pgwalk.sv
module sim_pgwalk;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_va = 0;
  logic [19:0] root_frame = 20'h00010;
  logic ready, done, fault, fault_prot, fault_level;
  logic [31:0] phys_addr, mem_addr, mem_wdata, mem_rdata;
  logic mem_req, mem_we, mem_ack;

  always #4 clk = ~clk;

  pgwalk u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .root_frame(root_frame),
    .ready(ready), .done(done), .fault(fault), .fault_prot(fault_prot),
    .fault_level(fault_level), .phys_addr(phys_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int total = 0, fails = 0, cyc = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] log_addr [8];
  logic        log_we   [8];
  int          nacc = 0;
  logic        pend = 0;
  logic [31:0] pend_addr = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial mem_ack = 0;
  initial mem_rdata = 0;
  always @(negedge clk) if (rst_n) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      if (pend) check(mem_addr == pend_addr, "R8 held address", mem_addr, pend_addr);
      if ($urandom % 3 == 0) begin
        if (nacc < 8) begin log_addr[nacc] = mem_addr; log_we[nacc] = mem_we; end
        nacc++;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        mem_ack = 1; pend = 0;
      end else begin pend = 1; pend_addr = mem_addr; end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [19:0] fr, input logic p, rw, us, a, d);
    return {fr, 5'd0, d, a, 2'd0, us, rw, p};
  endfunction

  task automatic walk(input logic [31:0] va, input logic wr, input logic us);
    logic [31:0] pa, ta, pde, pte, npde, npte, ephys;
    logic ef, ep, el; int ewr, nr;
    pa = {root_frame, va[31:22], 2'b00};
    pde = mem[pa];
    ta = {pde[31:12], va[21:12], 2'b00};
    pte = mem.exists(ta) ? mem[ta] : 32'h0;
    ef = 0; ep = 0; el = 0; ewr = 0; nr = 2; npde = pde; npte = pte; ephys = 0;
    if (!pde[0]) begin ef = 1; nr = 1; end
    else if (!pte[0]) begin ef = 1; el = 1; end
    else if ((wr && !pde[1]) || (us && !pde[2])) begin ef = 1; ep = 1; end
    else if ((wr && !pte[1]) || (us && !pte[2])) begin ef = 1; ep = 1; el = 1; end
    else begin
      ephys = {pte[31:12], va[11:0]};
      npde = pde | 32'h20;
      npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
      if (npde != pde) ewr++;
      if (npte != pte) ewr++;
    end
    while (!ready) @(negedge clk);
    nacc = 0;
    req_va = va; req_write = wr; req_user = us; req_valid = 1;
    @(negedge clk); req_valid = 0;
    while (!done) @(negedge clk);
    check(log_addr[0] == pa && !log_we[0], "R2 directory read address", log_addr[0], pa);
    if (nr == 2) check(log_addr[1] == ta && !log_we[1], "R3 table read address", log_addr[1], ta);
    check(nacc == nr + ewr, "R6/R7 access count", nacc, nr + ewr);
    check({fault, fault_prot, fault_level} == {ef, ep, el}, ef && !ep ? "R4 fault kind" : "R5 fault kind",
          {29'd0, fault, fault_prot, fault_level}, {29'd0, ef, ep, el});
    if (!ef) begin
      check(phys_addr == ephys, "R3 physical address", phys_addr, ephys);
      check(mem[pa] == npde, "R7 directory flags", mem[pa], npde);
      check(mem[ta] == npte, "R7 table flags", mem[ta], npte);
      if (ewr == 2) check(log_addr[2] == pa && log_we[2], "R7 directory written first", log_addr[2], pa);
    end else
      check(mem[pa] == pde && (nr == 1 || mem[ta] == pte), "R6 memory unchanged", mem[pa], pde);
    @(negedge clk);
    check(!done && ready, "R9 done is one pulse", {30'd0, done, ready}, 32'd1);
  endtask

  task automatic setup(input logic [31:0] va, input logic [31:0] pde, input logic [31:0] pte);
    mem[{root_frame, va[31:22], 2'b00}] = pde;
    mem[{pde[31:12], va[21:12], 2'b00}] = pte;
  endtask

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    check(ready && !done && !mem_req, "R1 reset state", {29'd0, ready, done, mem_req}, 32'd4);
    rst_n = 1;
    @(negedge clk);
    check(ready && !mem_req, "R1 idle after reset", {30'd0, ready, mem_req}, 32'd2);
    // directed corners
    setup(32'h0040_1abc, mk(20'h00100, 0, 1, 1, 0, 0), 32'h0);
    walk(32'h0040_1abc, 0, 0);                                     // R4 dir not present
    setup(32'h0080_2123, mk(20'h00101, 1, 1, 1, 0, 0), mk(20'h55555, 0, 1, 1, 0, 0));
    walk(32'h0080_2123, 1, 1);                                     // R4 table not present
    setup(32'h00c0_3fff, mk(20'h00102, 1, 0, 1, 0, 0), mk(20'h12345, 1, 1, 1, 0, 0));
    walk(32'h00c0_3fff, 1, 0);                                     // R5 dir denies write
    setup(32'h0100_4001, mk(20'h00103, 1, 1, 1, 0, 0), mk(20'h23456, 1, 1, 0, 0, 0));
    walk(32'h0100_4001, 0, 1);                                     // R5 table denies user
    setup(32'h0140_5555, mk(20'h00104, 1, 1, 1, 0, 0), mk(20'hfedcb, 1, 1, 1, 0, 0));
    walk(32'h0140_5555, 1, 1);                                     // R7 both written, dirty set
    walk(32'h0140_5555, 1, 1);                                     // R7 no write-back second time
    walk(32'hffff_ffff & {root_frame[9:0], 22'h3fffff}, 0, 0);     // may hit any entry
    setup(32'hffc0_0000, mk(20'h00105, 1, 0, 0, 1, 0), mk(20'h0000f, 1, 0, 0, 0, 1));
    walk(32'hffc0_0000, 0, 0);                                     // R7 table only written
    // random walks
    for (int n = 0; n < 600; n++) begin
      logic [31:0] va, pde, pte;
      va = {8'd0, 2'($urandom % 4), 3'($urandom % 8), 7'd0, 12'($urandom)};
      va[31:22] = 10'($urandom % 4);
      pde = mk(20'h00200 + 20'(va[23:22]), ($urandom % 8) != 0, ($urandom % 4) != 0,
               ($urandom % 4) != 0, 1'($urandom), 1'($urandom));
      pte = mk(20'($urandom), ($urandom % 8) != 0, ($urandom % 4) != 0,
               ($urandom % 4) != 0, 1'($urandom), 1'($urandom));
      setup(va, pde, pte);
      walk(va, 1'($urandom), 1'($urandom));
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule